// File: doc/BRIEF.md
# Serial Flash Upper Status Byte

This block keeps the high byte of a serial flash status register. Three kinds of bits share it, each with its own write rule. Ordinary configuration bits take whatever a status write gives them. One-time-programmable lock bits can only ever be set. Hardware flags are driven by device events and cannot be written by the host. The command decoder raises single-cycle pulses for the write-enable, write-disable, status-write, suspend and resume commands. A power-cycle pulse marks a supply interruption. The array and security-region logic read the assembled byte and the decoded lock and quad-enable outputs.

A status write takes effect only while the write-enable latch is set. An accepted write clears the latch. Lock bits merge the written value with the stored value by OR, so a written 0 never clears a lock. The suspend flag sets on a suspend command and clears on a resume command or a power cycle. The high-performance flag follows the mode indication one clock late. The lock bits and configuration bits survive a power cycle. Only the reset input returns them to their blank defaults.

Top module: `fsr_upper`

## Requirements
- R1: After reset, `sr_hi` reads 0x00 and `quad_en`, `sec_lock` and `wel` all read 0.
- R2: A status write while `wel` is 0 leaves every bit of `sr_hi` unchanged.
- R3: `we_cmd` sets `wel` on the next clock. `wd_cmd` clears it, and wins when both arrive together. An accepted status write clears `wel`, even if `we_cmd` arrives in the same cycle.
- R4: Bit 1 of `sr_hi` is the quad-enable bit. An accepted write loads it from `wr_data[1]`, and `quad_en` equals it.
- R5: Bit 6 of `sr_hi` is the protection-complement bit. An accepted write loads it from `wr_data[6]`.
- R6: Bits 3, 4 and 5 of `sr_hi` are lock bits. An accepted write ORs `wr_data[5:3]` into them, so each can be set on its own and none ever returns to 0, not even on a power cycle.
- R7: `sec_lock[i]` equals `sr_hi[3+i]` for i = 0..2.
- R8: Bit 7 of `sr_hi` is the suspend flag. It becomes 1 on the clock after `suspend_op`, and status writes never change it.
- R9: `resume_op` or `pwr_cycle` clears the suspend flag on the next clock, overriding a simultaneous `suspend_op`. `pwr_cycle` also clears `wel`, while bits 1 and 3 to 6 keep their values.
- R10: Bit 2 of `sr_hi` is the high-performance flag. It equals `hpm_active` as sampled at the previous clock, and status writes never change it.
- R11: Bit 0 of `sr_hi` is reserved. It always reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset to blank defaults |
| we_cmd | input | 1 | Write-enable command pulse |
| wd_cmd | input | 1 | Write-disable command pulse |
| wr_req | input | 1 | Status-write command pulse |
| wr_data | input | 8 | Byte carried by the status write |
| suspend_op | input | 1 | Suspend command pulse |
| resume_op | input | 1 | Resume command pulse |
| pwr_cycle | input | 1 | Power-cycle event pulse |
| hpm_active | input | 1 | High-performance mode indication |
| sr_hi | output | 8 | Assembled upper status byte |
| quad_en | output | 1 | Quad-enable, selects data function of the shared pins |
| sec_lock | output | 3 | Per-region security lock |
| wel | output | 1 | Write-enable latch |

## Verification
Every storage element drives a bit of `sr_hi` or `wel` directly. A wrong internal state therefore shows at the ports on the first clock after the event that caused it, with no hidden pipeline. A lock that clears, or a flag that takes a write, appears as a changed bit the cycle after the offending write or power cycle. A latch that stays set appears on `wel` one cycle after the write that should have consumed it.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int SR_W    = 8;
  localparam int N_LOCK  = 3;
  localparam int B_RSV   = 0;
  localparam int B_QE    = 1;
  localparam int B_HPF   = 2;
  localparam int B_LB_LO = 3;
  localparam int B_CMP   = B_LB_LO + N_LOCK;
  localparam int B_SUS   = B_CMP + 1;

  typedef struct packed {
    logic              cmp;
    logic [N_LOCK-1:0] lock;
    logic              qe;
  } cfg_t;

  typedef enum logic [1:0] {SUS_HOLD, SUS_SET, SUS_CLR} sus_op_e;

  // sticky merge for one-time-programmable bits
  function automatic logic lock_merge(input logic old_b, input logic new_b);
    return old_b | new_b;
  endfunction

  // clearing events outrank the setting event
  function automatic sus_op_e sus_decide(input logic pwr, input logic res,
                                         input logic susp);
    if (pwr || res) return SUS_CLR;
    if (susp)       return SUS_SET;
    return SUS_HOLD;
  endfunction

  function automatic logic wel_next(input logic cur, input logic set_c,
                                    input logic clr_c, input logic consumed);
    if (clr_c || consumed) return 1'b0;
    if (set_c)             return 1'b1;
    return cur;
  endfunction

  function automatic logic [SR_W-1:0] pack_sr(input cfg_t c, input logic hpf,
                                               input logic sus);
    logic [SR_W-1:0] v;
    v = '0;
    v[B_QE]  = c.qe;
    v[B_HPF] = hpf;
    v[B_LB_LO +: N_LOCK] = c.lock;
    v[B_CMP] = c.cmp;
    v[B_SUS] = sus;
    v[B_RSV] = 1'b0;
    return v;
  endfunction
endpackage

// File: rtl/fsr_wel.sv
module fsr_wel (
  input  logic clk,
  input  logic rst_n,
  input  logic we_cmd,
  input  logic wd_cmd,
  input  logic pwr_cycle,
  input  logic wr_accept,
  output logic wel
);
  import fsr_pkg::*;
  logic wel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wel_q <= 1'b0;
    else        wel_q <= wel_next(wel_q, we_cmd, wd_cmd || pwr_cycle, wr_accept);
  end

  assign wel = wel_q;
endmodule

// File: rtl/fsr_cfg.sv
module fsr_cfg (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_accept,
  input  logic                      wr_qe,
  input  logic                      wr_cmp,
  input  logic [fsr_pkg::N_LOCK-1:0] wr_lock,
  output fsr_pkg::cfg_t             cfg
);
  import fsr_pkg::*;
  logic              qe_q, cmp_q;
  logic [N_LOCK-1:0] lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qe_q  <= 1'b0;
      cmp_q <= 1'b0;
    end else if (wr_accept) begin
      qe_q  <= wr_qe;
      cmp_q <= wr_cmp;
    end
  end

  for (genvar i = 0; i < N_LOCK; i++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lock_q[i] <= 1'b0;
      else if (wr_accept) lock_q[i] <= lock_merge(lock_q[i], wr_lock[i]);
    end
  end

  assign cfg.qe   = qe_q;
  assign cfg.cmp  = cmp_q;
  assign cfg.lock = lock_q;
endmodule

// File: rtl/fsr_flags.sv
module fsr_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_op,
  input  logic resume_op,
  input  logic pwr_cycle,
  input  logic hpm_active,
  output logic sus,
  output logic hpf
);
  import fsr_pkg::*;
  logic    sus_q, hpf_q;
  sus_op_e sus_op;

  assign sus_op = sus_decide(pwr_cycle, resume_op, suspend_op);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sus_q <= 1'b0;
      hpf_q <= 1'b0;
    end else begin
      hpf_q <= hpm_active;
      case (sus_op)
        SUS_SET: sus_q <= 1'b1;
        SUS_CLR: sus_q <= 1'b0;
        default: sus_q <= sus_q;
      endcase
    end
  end

  assign sus = sus_q;
  assign hpf = hpf_q;
endmodule

// File: rtl/fsr_upper.sv
module fsr_upper (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we_cmd,
  input  logic       wd_cmd,
  input  logic       wr_req,
  input  logic [7:0] wr_data,
  input  logic       suspend_op,
  input  logic       resume_op,
  input  logic       pwr_cycle,
  input  logic       hpm_active,
  output logic [7:0] sr_hi,
  output logic       quad_en,
  output logic [2:0] sec_lock,
  output logic       wel
);
  import fsr_pkg::*;

  cfg_t cfg;
  logic sus, hpf;
  logic wr_accept;
  logic unused_wr_bits;

  // named event for the checker
  assign wr_accept      = wr_req && wel;
  assign unused_wr_bits = ^{wr_data[B_RSV], wr_data[B_HPF], wr_data[B_SUS]};

  fsr_wel u_wel (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_cmd    (we_cmd),
    .wd_cmd    (wd_cmd),
    .pwr_cycle (pwr_cycle),
    .wr_accept (wr_accept),
    .wel       (wel)
  );

  fsr_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_accept (wr_accept),
    .wr_qe     (wr_data[B_QE]),
    .wr_cmp    (wr_data[B_CMP]),
    .wr_lock   (wr_data[B_LB_LO +: N_LOCK]),
    .cfg       (cfg)
  );

  fsr_flags u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .suspend_op (suspend_op),
    .resume_op  (resume_op),
    .pwr_cycle  (pwr_cycle),
    .hpm_active (hpm_active),
    .sus        (sus),
    .hpf        (hpf)
  );

  assign sr_hi    = pack_sr(cfg, hpf, sus);
  assign quad_en  = cfg.qe;
  assign sec_lock = cfg.lock;
endmodule

// File: rtl/fsr_upper_chk.sv
module fsr_upper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_req,
  input logic       wr_accept,
  input logic       wel,
  input logic       suspend_op,
  input logic       resume_op,
  input logic       pwr_cycle,
  input logic       hpm_active,
  input logic [7:0] sr_hi,
  input logic [2:0] sec_lock
);
  AST_WRITE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wel) |=> $stable({sr_hi[6:3], sr_hi[1]})); // R2
  AST_WEL_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !wel); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sec_lock) & ~sec_lock) == 3'b000)); // R6
  AST_SUS_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (suspend_op && !resume_op && !pwr_cycle) |=> sr_hi[7]); // R8
  AST_SUS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (resume_op || pwr_cycle) |=> !sr_hi[7]); // R9
  AST_HPF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sr_hi[2] == $past(hpm_active))); // R10
endmodule

bind fsr_upper fsr_upper_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_req     (wr_req),
  .wr_accept  (wr_accept),
  .wel        (wel),
  .suspend_op (suspend_op),
  .resume_op  (resume_op),
  .pwr_cycle  (pwr_cycle),
  .hpm_active (hpm_active),
  .sr_hi      (sr_hi),
  .sec_lock   (sec_lock)
);

// File: tb/fsr_upper_tb.sv
module fsr_upper_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we_cmd = 1'b0, wd_cmd = 1'b0, wr_req = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       suspend_op = 1'b0, resume_op = 1'b0, pwr_cycle = 1'b0;
  logic       hpm_active = 1'b0;
  logic [7:0] sr_hi;
  logic       quad_en, wel;
  logic [2:0] sec_lock;
  int         n_chk = 0, n_err = 0;

  always #2 clk = ~clk;

  fsr_upper u_dut (
    .clk(clk), .rst_n(rst_n), .we_cmd(we_cmd), .wd_cmd(wd_cmd),
    .wr_req(wr_req), .wr_data(wr_data), .suspend_op(suspend_op),
    .resume_op(resume_op), .pwr_cycle(pwr_cycle), .hpm_active(hpm_active),
    .sr_hi(sr_hi), .quad_en(quad_en), .sec_lock(sec_lock), .wel(wel)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // one clock with the given pulses; returns just after the falling edge
  task automatic tick();
    @(negedge clk);
    we_cmd = 0; wd_cmd = 0; wr_req = 0;
    suspend_op = 0; resume_op = 0; pwr_cycle = 0;
  endtask

  task automatic sr_write(input logic [7:0] d, input logic enable);
    if (enable) begin we_cmd = 1; tick(); end
    wr_req = 1; wr_data = d; tick();
  endtask

  task automatic t_reset();
    chk("R1 sr", sr_hi, 8'h00);
    chk("R1 wel/qe/lock", {3'b0, wel, quad_en, sec_lock}, 8'h00);
  endtask

  task automatic t_gate();
    sr_write(8'hFF, 1'b0);
    chk("R2 no-wel write", sr_hi, 8'h00);
    we_cmd = 1; tick();
    chk("R3 wel set", {7'b0, wel}, 8'h01);
    we_cmd = 1; wd_cmd = 1; tick();
    chk("R3 wd wins", {7'b0, wel}, 8'h00);
    we_cmd = 1; tick();
    wr_req = 1; wr_data = 8'h00; we_cmd = 1; tick();
    chk("R3 write+we clears", {7'b0, wel}, 8'h00);
  endtask

  task automatic t_cfg();
    sr_write(8'h42, 1'b1);
    chk("R4 R5 qe cmp", sr_hi, 8'h42);
    chk("R4 quad_en", {7'b0, quad_en}, 8'h01);
    chk("R3 consumed", {7'b0, wel}, 8'h00);
    sr_write(8'h85, 1'b1);
    chk("R11 R8 R10 ro bits", sr_hi, 8'h00);
  endtask

  task automatic t_locks();
    sr_write(8'h10, 1'b1);
    chk("R6 lb2", sr_hi, 8'h10);
    chk("R7 lock out", {5'b0, sec_lock}, 8'h02);
    sr_write(8'h08, 1'b1);
    chk("R6 or merge", sr_hi, 8'h18);
    sr_write(8'h00, 1'b1);
    chk("R6 no clear", sr_hi, 8'h18);
    sr_write(8'h20, 1'b1);
    chk("R7 all locks", {5'b0, sec_lock}, 8'h07);
  endtask

  task automatic t_suspend();
    suspend_op = 1; tick();
    chk("R8 sus set", sr_hi, 8'hB8);
    sr_write(8'h00, 1'b1);
    chk("R8 write ignored", sr_hi, 8'hB8);
    resume_op = 1; tick();
    chk("R9 resume", sr_hi, 8'h38);
    suspend_op = 1; resume_op = 1; tick();
    chk("R9 resume wins", sr_hi, 8'h38);
  endtask

  task automatic t_power();
    sr_write(8'h42, 1'b1);
    chk("R4 qe again", sr_hi, 8'h7A);
    we_cmd = 1; suspend_op = 1; tick();
    chk("R8 sus and wel", {sr_hi[7], wel}, {1'b1, 1'b1});
    pwr_cycle = 1; tick();
    chk("R9 pwr keeps nv", sr_hi, 8'h7A);
    chk("R9 pwr clears wel", {7'b0, wel}, 8'h00);
    suspend_op = 1; pwr_cycle = 1; tick();
    chk("R9 pwr wins", sr_hi, 8'h7A);
  endtask

  task automatic t_hpf();
    hpm_active = 1; tick();
    chk("R10 hpf on", sr_hi, 8'h7E);
    sr_write(8'h00, 1'b1);
    chk("R10 write ignored", sr_hi, 8'h3C);
    hpm_active = 0; tick();
    chk("R10 hpf off", sr_hi, 8'h38);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_err++; n_chk++;
        $display("FAIL watchdog: got %0d expected <= 5000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_gate();
    t_cfg();
    t_locks();
    t_suspend();
    t_power();
    t_hpf();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule